// File: doc/BRIEF.md
# Circular Fractional Delay Line

This block delays an audio sample stream by a distance that has an integer part and a fractional part. It is meant to serve as the delay element of a waveguide-style synthesis voice. Storage is a ring of 2^ADDR_W samples. Every sample is written into the ring on its strobe, and the write address steps forward by one and wraps. The delay setting never changes how much of the ring is in use.

The read tap trails the write address by the integer delay. The output is a linear blend of the sample at the tap and the next older sample, weighted by an 8-bit fraction. Delay changes are picked up at the next strobe and leave the stored history untouched, so a new tap position reads data that is already in the ring. After reset no memory is cleared. Instead, a fill counter marks which positions have never been written, and those positions read as zero.

Top module: `frac_delay_line`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_sample` is 0 and `out_valid` is 0.
- R2: Each strobe (`in_valid` high for one cycle) stores `in_sample` and moves the write position forward by one, wrapping after 2^ADDR_W strobes. Delays keep working across any number of wraps.
- R3: When `delay_frac` is 0, the output produced by a strobe equals the sample written D strobes earlier, where D is the effective integer delay.
- R4: When `delay_frac` = f (unsigned, 0..255), the output is s0 + floor(f*(s1-s0)/256). Here s0 is the sample written D strobes earlier and s1 is the sample written D+1 strobes earlier, both signed two's complement.
- R5: A `delay_int` of 0 is treated as 1.
- R6: A `delay_int` above 2^ADDR_W-2 is treated as 2^ADDR_W-2.
- R7: A sample position that has not been written since reset reads as zero. With a delay of D, the first D outputs after reset are therefore 0.
- R8: A new delay setting applies from the next strobe onward, and the stored history is kept.
- R9: `out_valid` pulses high in the cycle after each strobe and is low otherwise. `out_sample` holds its value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DATA_W | Incoming signed sample |
| delay_int | input | ADDR_W | Integer delay in samples |
| delay_frac | input | FRAC_W | Fractional delay, unsigned, in units of 1/2^FRAC_W |
| out_valid | output | 1 | One-cycle pulse after each strobe |
| out_sample | output | DATA_W | Delayed, interpolated signed sample |

## Verification
The hardest situation to reach is a tap that straddles the wrap point of the ring while the delay is changing, with one of the two interpolated neighbours still unwritten since reset. The stimulus gets there with runs longer than the ring at mixed delays. These runs start right after a reset and then jump to the largest clamped delay. Full-scale samples of opposite sign are mixed in so that the neighbour difference uses its full extended range.

// File: rtl/fdl_pkg.sv
// Shared defaults for the fractional delay line.
// Assumes: users override through the top-level parameters only.
package fdl_pkg;
    localparam int FDL_ADDR_W = 6;
    localparam int FDL_DATA_W = 16;
    localparam int FDL_FRAC_W = 8;
endpackage

// File: rtl/fdl_ring.sv
// Sample ring: storage of 2^ADDR_W words, write pointer and fill counter.
// Assumes: one write per strobe; reads are combinational and never hit the
// address being written in the same cycle (the tap logic guarantees this).
module fdl_ring #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr0,
    input  logic [ADDR_W-1:0] rd_addr1,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] filled
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] FILL_MAX = ADDR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming sample; contents are not reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Advance the write pointer modulo DEPTH and count writes up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            filled <= '0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (filled != FILL_MAX) filled <= filled + 1'b1;
        end
    end

    // Two combinational read ports.
    assign rd_data0 = mem[rd_addr0];
    assign rd_data1 = mem[rd_addr1];

    // R2: pointer steps by exactly one per strobe, wrapping
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1)));
    a_r2_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wr_ptr));
endmodule

// File: rtl/fdl_tap.sv
// Tap locator: clamps the integer delay, forms the two read addresses behind
// the write pointer and flags whether each has been written since reset.
// Assumes: filled saturates at 2^ADDR_W-1.
module fdl_tap #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] wr_ptr,
    input  logic [ADDR_W-1:0] filled,
    input  logic [ADDR_W-1:0] delay_int,
    output logic [ADDR_W-1:0] addr_near,
    output logic [ADDR_W-1:0] addr_far,
    output logic              near_ok,
    output logic              far_ok
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] D_MAX = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] D_MIN = ADDR_W'(1);

    logic [ADDR_W-1:0] eff;

    // Clamp the delay into [1, DEPTH-2].
    always_comb begin
        if (delay_int < D_MIN)      eff = D_MIN;
        else if (delay_int > D_MAX) eff = D_MAX;
        else                        eff = delay_int;
    end

    // Tap addresses: newer neighbour at the delay, older one just behind it.
    assign addr_near = wr_ptr - eff;
    assign addr_far  = wr_ptr - eff - 1'b1;

    // A neighbour is valid only if that many samples have been written.
    assign near_ok = ({1'b0, eff} <= {1'b0, filled});
    assign far_ok  = ({1'b0, eff} + 1'b1 <= {1'b0, filled});
endmodule

// File: rtl/fdl_lerp.sv
// Linear interpolator: near + floor(frac * (far - near) / 2^FRAC_W).
// Assumes: signed two's complement samples, unsigned fraction.
module fdl_lerp #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8
) (
    input  logic signed [DATA_W-1:0] near_s,
    input  logic signed [DATA_W-1:0] far_s,
    input  logic        [FRAC_W-1:0] frac,
    output logic signed [DATA_W-1:0] result
);
    localparam int DIFF_W = DATA_W + 1;
    localparam int PROD_W = DIFF_W + FRAC_W + 1;

    logic signed [DIFF_W-1:0] diff;
    logic signed [FRAC_W:0]   frac_s;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] step;
    logic signed [PROD_W-1:0] sum;

    // Extended difference, weighted step with floor rounding, and sum.
    always_comb begin
        diff   = DIFF_W'(far_s) - DIFF_W'(near_s);
        frac_s = {1'b0, frac};
        prod   = PROD_W'(diff) * PROD_W'(frac_s);
        step   = prod >>> FRAC_W;
        sum    = PROD_W'(near_s) + step;
        result = sum[DATA_W-1:0];
    end
endmodule

// File: rtl/frac_delay_line.sv
// Circular fractional delay line. On each strobe it writes the new sample,
// reads two neighbours behind the write pointer and registers their linear
// blend. Never-written positions read as zero.
// Assumes: in_valid is a single-cycle strobe; delay may change at any time.
module frac_delay_line #(
    parameter int ADDR_W = fdl_pkg::FDL_ADDR_W,
    parameter int DATA_W = fdl_pkg::FDL_DATA_W,
    parameter int FRAC_W = fdl_pkg::FDL_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic [ADDR_W-1:0] delay_int,
    input  logic [FRAC_W-1:0] delay_frac,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);
    logic [ADDR_W-1:0] wr_ptr, filled, addr_near, addr_far;
    logic [DATA_W-1:0] rd_near, rd_far;
    logic              near_ok, far_ok;
    logic signed [DATA_W-1:0] near_s, far_s, blend;

    fdl_ring #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_data(in_sample),
        .rd_addr0(addr_near), .rd_addr1(addr_far),
        .rd_data0(rd_near), .rd_data1(rd_far),
        .wr_ptr(wr_ptr), .filled(filled)
    );

    fdl_tap #(.ADDR_W(ADDR_W)) u_tap (
        .wr_ptr(wr_ptr), .filled(filled), .delay_int(delay_int),
        .addr_near(addr_near), .addr_far(addr_far),
        .near_ok(near_ok), .far_ok(far_ok)
    );

    // Substitute zero for neighbours not yet written since reset.
    assign near_s = near_ok ? $signed(rd_near) : '0;
    assign far_s  = far_ok  ? $signed(rd_far)  : '0;

    fdl_lerp #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_lerp (
        .near_s(near_s), .far_s(far_s), .frac(delay_frac), .result(blend)
    );

    // Register the blended output and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sample <= blend;
        end
    end

    // R9: valid pulse follows each strobe and only a strobe
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9: output holds between strobes
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));
    // R7: nothing written yet means a zero output
    a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && filled == '0) |=> (out_sample == '0));
    // R2: taps never collide with the slot being written
    a_r2_tap_clear: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (addr_near != wr_ptr && addr_far != wr_ptr));
endmodule

// File: tb/frac_delay_line_test.sv
module frac_delay_line_test;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int FW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int ROWS = 8;
    // Per row: integer delay, fraction, number of strobes, requirement code.
    localparam int TAB_DI [ROWS] = '{3, 3, 20, 0, 5, 63, 1, 62};
    localparam int TAB_DF [ROWS] = '{0, 0, 128, 0, 255, 64, 200, 0};
    localparam int TAB_N  [ROWS] = '{6, 4, 80, 5, 10, 12, 6, 70};
    localparam int TAB_RQ [ROWS] = '{7, 3, 4, 5, 4, 6, 4, 2};

    logic clk = 0, rst_n = 0, in_valid = 0;
    logic [DW-1:0] in_sample = '0;
    logic [AW-1:0] delay_int = '0;
    logic [FW-1:0] delay_frac = '0;
    logic out_valid;
    logic [DW-1:0] out_sample;

    int checks = 0, errors = 0;
    int hist [0:511];
    int n = 0;

    always #5 clk = ~clk;

    frac_delay_line #(.ADDR_W(AW), .DATA_W(DW), .FRAC_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .delay_int(delay_int), .delay_frac(delay_frac),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic string tag(input int c);
        case (c)
            2: return "R2"; 3: return "R3"; 4: return "R4"; 5: return "R5";
            6: return "R6"; 7: return "R7"; default: return "R8";
        endcase
    endfunction

    function automatic int pattern(input int k);
        if (k % 7 == 3) return 32767;
        if (k % 7 == 5) return -32768;
        return ((k * 1237 + 91) % 4001) - 2000;
    endfunction

    function automatic int old_sample(input int idx);
        return (idx < 0) ? 0 : hist[idx];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One strobe; check output and valid one edge later.
    task automatic strobe(input int s, input int di, input int df, input string req);
        int d, s0, s1, exp;
        d = (di < 1) ? 1 : ((di > DEPTH - 2) ? DEPTH - 2 : di);
        s0 = old_sample(n - d);
        s1 = old_sample(n - d - 1);
        exp = s0 + (((s1 - s0) * df) >>> 8);
        @(negedge clk);
        in_sample = DW'(s); delay_int = AW'(di); delay_frac = FW'(df); in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        check({req, " R9 valid"}, int'(out_valid), 1);
        check(req, int'($signed(out_sample)), exp);
        hist[n] = s;
        n++;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 data in reset", int'(out_sample), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 data after reset", int'(out_sample), 0);
        n = 0;
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int held;
        do_reset();
        // Table walk: each row runs a delay setting over several strobes (R8 on change).
        for (int r = 0; r < ROWS; r++) begin
            for (int k = 0; k < TAB_N[r]; k++)
                strobe(pattern(n), TAB_DI[r], TAB_DF[r], (k == 0 && r > 0) ? "R8" : tag(TAB_RQ[r]));
        end
        // R9: output holds and valid stays low with no strobe.
        held = int'($signed(out_sample));
        repeat (4) @(negedge clk);
        check("R9 hold data", int'($signed(out_sample)), held);
        check("R9 no valid", int'(out_valid), 0);
        // R7: second reset, large clamped delay reads zeros until filled.
        do_reset();
        for (int k = 0; k < 8; k++) strobe(pattern(k + 300), 63, 90, "R7");
        // R3: back to a short integer delay after only a few writes.
        for (int k = 0; k < 5; k++) strobe(pattern(k + 500), 2, 0, "R3");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule